// File: doc/BRIEF.md
# Trace Buffer Register Scan Port

This block lets a debug host reach the control and status registers of an on-chip trace buffer through a serial data register. The host moves a 40-bit word through the port on each scan. The word holds a 32-bit data field, a 7-bit register address and a 1-bit direction flag. The TAP controller around the block supplies the capture, shift and update strobes and a select line. Instruction decoding and chain selection stay outside the block.

When the update strobe arrives, a write stores the data field into the addressed register. A read instead latches the addressed value, and that value leaves the port during the data field of the next scan. Reading a register therefore takes two scans. Reading the RAM-data address also advances the buffer read pointer, so a run of reads drains the trace memory word by word.

The block holds the host-writable registers itself. It takes the status flags and the RAM word at the read pointer from the trace-buffer core.

Top module: `trace_reg_port`

## Requirements
- R1: The shift register is 40 bits. Each clock with `sel` and `shift` high moves it one place toward `tdo` and enters `tdi` at the far end. `tdo` always shows the bit next to leave. The bits leave in this order: bit 0 is the direction flag, bits 1..7 are the address (LSB first) and bits 8..39 are the data field (LSB first). A scanned-in word uses the same layout.
- R2: A clock with `sel` and `capture` high loads the data field with the pending read result and loads zeros into the address and flag positions.
- R3: At a clock with `sel` and `update` high and flag 1, the data field is written to the addressed register. The writable registers are 5 (read pointer, low PTR_W bits), 6 (write pointer, low PTR_W bits), 7 (trigger count, TRIG_W bits) and 8 (control, CTRL_W bits). Each reads back zero-extended.
- R4: At an update with flag 0, the addressed value becomes the pending read result. The next scan returns it in its data field.
- R5: A read of address 4 returns `ram_rdata`, which is the word at `ram_raddr` (the read pointer). The same read then increments the read pointer modulo 2^PTR_W.
- R6: Writes to addresses 0..4 and 9..127 change no register. Reads of 9..127 return zero.
- R7: Reset clears the pending result, both pointers, the trigger count, the control register and the shift register.
- R8: While `sel` is low, the capture, shift and update strobes have no effect.
- R9: Address 0 reads ID_VAL. Address 1 reads 2^PTR_W. Address 2 reads WIDTH_VAL. Address 3 reads `status_in` zero-extended.
- R10: `ram_raddr`, `wptr_o`, `trig_o` and `ctrl_o` always show the current read pointer, write pointer, trigger count and control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | This data register is selected |
| capture | input | 1 | Capture strobe |
| shift | input | 1 | Shift strobe |
| update | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| status_in | input | STAT_W | Status flags from the trace core |
| ram_rdata | input | 32 | Trace RAM word at `ram_raddr` |
| ram_raddr | output | PTR_W | Trace RAM read pointer |
| wptr_o | output | PTR_W | Trace RAM write pointer |
| trig_o | output | TRIG_W | Trigger count |
| ctrl_o | output | CTRL_W | Control register |

## Verification
The hardest situation to reach is the read pointer wrapping while reads stream back to back. Each of those reads returns the word fetched by the scan before it, so an off-by-one in either the pointer or the one-scan delay looks plausible unless the model follows both. The stimulus presets the pointer near the top through address 5 and then issues more than 2^PTR_W consecutive RAM-data reads. Random scans mix writes, reads, out-of-range addresses and read-only targets on top of that.

// File: rtl/trp_pkg.sv
package trp_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 7;
  localparam int SR_W   = DATA_W + ADDR_W + 1;

  localparam logic [ADDR_W-1:0] REG_IDENT   = 7'd0;
  localparam logic [ADDR_W-1:0] REG_DEPTH   = 7'd1;
  localparam logic [ADDR_W-1:0] REG_WIDTH   = 7'd2;
  localparam logic [ADDR_W-1:0] REG_STATUS  = 7'd3;
  localparam logic [ADDR_W-1:0] REG_RAMDATA = 7'd4;
  localparam logic [ADDR_W-1:0] REG_RDPTR   = 7'd5;
  localparam logic [ADDR_W-1:0] REG_WRPTR   = 7'd6;
  localparam logic [ADDR_W-1:0] REG_TRIG    = 7'd7;
  localparam logic [ADDR_W-1:0] REG_CTRL    = 7'd8;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [ADDR_W-1:0] addr;
    logic              wr;
  } scan_word_t;
endpackage

// File: rtl/trp_shift.sv
module trp_shift
  import trp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              shf_en,
  input  logic              tdi,
  input  logic [DATA_W-1:0] cap_data,
  output scan_word_t        word_q,
  output logic              tdo
);
  scan_word_t word_d;

  always_comb begin
    word_d = word_q;
    if (cap_en) begin
      word_d.data = cap_data;
      word_d.addr = '0;
      word_d.wr   = 1'b0;
    end else if (shf_en) begin
      word_d = scan_word_t'({tdi, word_q[SR_W-1:1]});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (cap_en || shf_en) word_q <= word_d;
  end

  assign tdo = word_q.wr;
endmodule

// File: rtl/trp_regbank.sv
module trp_regbank
  import trp_pkg::*;
#(
  parameter int          PTR_W     = 4,
  parameter int          TRIG_W    = 32,
  parameter int          CTRL_W    = 2,
  parameter int          STAT_W    = 4,
  parameter logic [31:0] ID_VAL    = 32'h5A31_0C07,
  parameter logic [31:0] WIDTH_VAL = 32'd32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic              upd_wr,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [DATA_W-1:0] upd_data,
  input  logic [STAT_W-1:0] status_in,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] rd_result,
  output logic [PTR_W-1:0]  rptr_q,
  output logic [PTR_W-1:0]  wptr_q,
  output logic [TRIG_W-1:0] trig_q,
  output logic [CTRL_W-1:0] ctrl_q
);
  localparam logic [DATA_W-1:0] DEPTH_VAL = DATA_W'(1) << PTR_W;

  logic [DATA_W-1:0] rd_mux, rd_result_d;
  logic [PTR_W-1:0]  rptr_d, wptr_d;
  logic [TRIG_W-1:0] trig_d;
  logic [CTRL_W-1:0] ctrl_d;
  logic              do_wr, do_rd;

  assign do_wr = upd_en &&  upd_wr;
  assign do_rd = upd_en && !upd_wr;

  always_comb begin
    case (upd_addr)
      REG_IDENT:   rd_mux = ID_VAL;
      REG_DEPTH:   rd_mux = DEPTH_VAL;
      REG_WIDTH:   rd_mux = WIDTH_VAL;
      REG_STATUS:  rd_mux = DATA_W'(status_in);
      REG_RAMDATA: rd_mux = ram_rdata;
      REG_RDPTR:   rd_mux = DATA_W'(rptr_q);
      REG_WRPTR:   rd_mux = DATA_W'(wptr_q);
      REG_TRIG:    rd_mux = DATA_W'(trig_q);
      REG_CTRL:    rd_mux = DATA_W'(ctrl_q);
      default:     rd_mux = '0;
    endcase
  end

  always_comb begin
    rd_result_d = rd_result;
    rptr_d      = rptr_q;
    wptr_d      = wptr_q;
    trig_d      = trig_q;
    ctrl_d      = ctrl_q;
    if (do_rd) begin
      rd_result_d = rd_mux;
      if (upd_addr == REG_RAMDATA) rptr_d = rptr_q + 1'b1;
    end
    if (do_wr) begin
      case (upd_addr)
        REG_RDPTR: rptr_d = upd_data[PTR_W-1:0];
        REG_WRPTR: wptr_d = upd_data[PTR_W-1:0];
        REG_TRIG:  trig_d = upd_data[TRIG_W-1:0];
        REG_CTRL:  ctrl_d = upd_data[CTRL_W-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_result <= '0;
      rptr_q    <= '0;
      wptr_q    <= '0;
      trig_q    <= '0;
      ctrl_q    <= '0;
    end else if (upd_en) begin
      rd_result <= rd_result_d;
      rptr_q    <= rptr_d;
      wptr_q    <= wptr_d;
      trig_q    <= trig_d;
      ctrl_q    <= ctrl_d;
    end
  end
endmodule

// File: rtl/trace_reg_port.sv
module trace_reg_port
  import trp_pkg::*;
#(
  parameter int          PTR_W     = 4,
  parameter int          TRIG_W    = 32,
  parameter int          CTRL_W    = 2,
  parameter int          STAT_W    = 4,
  parameter logic [31:0] ID_VAL    = 32'h5A31_0C07,
  parameter logic [31:0] WIDTH_VAL = 32'd32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              capture,
  input  logic              shift,
  input  logic              update,
  input  logic              tdi,
  output logic              tdo,
  input  logic [STAT_W-1:0] status_in,
  input  logic [31:0]       ram_rdata,
  output logic [PTR_W-1:0]  ram_raddr,
  output logic [PTR_W-1:0]  wptr_o,
  output logic [TRIG_W-1:0] trig_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  scan_word_t        word_q;
  logic [DATA_W-1:0] rd_result;
  logic              cap_en, shf_en, upd_en;

  assign cap_en = sel && capture;
  assign shf_en = sel && shift;
  assign upd_en = sel && update;

  trp_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .shf_en   (shf_en),
    .tdi      (tdi),
    .cap_data (rd_result),
    .word_q   (word_q),
    .tdo      (tdo)
  );

  trp_regbank #(
    .PTR_W(PTR_W), .TRIG_W(TRIG_W), .CTRL_W(CTRL_W), .STAT_W(STAT_W),
    .ID_VAL(ID_VAL), .WIDTH_VAL(WIDTH_VAL)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (upd_en),
    .upd_wr    (word_q.wr),
    .upd_addr  (word_q.addr),
    .upd_data  (word_q.data),
    .status_in (status_in),
    .ram_rdata (ram_rdata),
    .rd_result (rd_result),
    .rptr_q    (ram_raddr),
    .wptr_q    (wptr_o),
    .trig_q    (trig_o),
    .ctrl_q    (ctrl_o)
  );
endmodule

// File: rtl/trp_checker.sv
module trp_checker
  import trp_pkg::*;
#(
  parameter int PTR_W  = 4,
  parameter int TRIG_W = 32,
  parameter int CTRL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              capture,
  input logic              update,
  input logic              tdo,
  input scan_word_t        word_q,
  input logic [PTR_W-1:0]  ram_raddr,
  input logic [PTR_W-1:0]  wptr_o,
  input logic [TRIG_W-1:0] trig_o,
  input logic [CTRL_W-1:0] ctrl_o
);
  AST_RAM_READ_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && update && !word_q.wr && word_q.addr == REG_RAMDATA)
      |=> ram_raddr == PTR_W'($past(ram_raddr) + 1'b1)); // R5

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && update && word_q.wr && word_q.addr == REG_CTRL)
      |=> ctrl_o == $past(word_q.data[CTRL_W-1:0])); // R3

  AST_RO_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && update && word_q.wr && (word_q.addr <= REG_RAMDATA || word_q.addr > REG_CTRL))
      |=> $stable(ram_raddr) && $stable(wptr_o) && $stable(trig_o) && $stable(ctrl_o)); // R6

  AST_DESELECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(ram_raddr) && $stable(wptr_o) && $stable(trig_o) && $stable(ctrl_o)
             && $stable(tdo)); // R8

  AST_CAPTURE_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && capture) |=> !tdo); // R2
endmodule

bind trace_reg_port trp_checker #(.PTR_W(PTR_W), .TRIG_W(TRIG_W), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .capture(capture), .update(update), .tdo(tdo),
  .word_q(word_q), .ram_raddr(ram_raddr), .wptr_o(wptr_o), .trig_o(trig_o), .ctrl_o(ctrl_o)
);

// File: tb/test_trace_reg_port.sv
module test_trace_reg_port;
  localparam int          PTR_W  = 4;
  localparam int          TRIG_W = 32;
  localparam int          CTRL_W = 2;
  localparam int          STAT_W = 4;
  localparam logic [31:0] IDV    = 32'h5A31_0C07;
  localparam logic [31:0] WIDV   = 32'd32;
  localparam int          DEPTH  = 1 << PTR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, capture = 1'b0, shift = 1'b0, update = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [STAT_W-1:0] status_in = '0;
  logic [31:0] ram_rdata;
  logic [PTR_W-1:0] ram_raddr, wptr_o;
  logic [TRIG_W-1:0] trig_o;
  logic [CTRL_W-1:0] ctrl_o;
  logic [31:0] mem [DEPTH];

  int errors = 0, checks = 0;
  logic [31:0] m_pend;
  logic [PTR_W-1:0] m_rptr, m_wptr;
  logic [TRIG_W-1:0] m_trig;
  logic [CTRL_W-1:0] m_ctrl;

  always #10 clk = ~clk;
  assign ram_rdata = mem[ram_raddr];

  trace_reg_port #(.PTR_W(PTR_W), .TRIG_W(TRIG_W), .CTRL_W(CTRL_W), .STAT_W(STAT_W),
                   .ID_VAL(IDV), .WIDTH_VAL(WIDV)) i_trace_reg_port (
    .clk(clk), .rst_n(rst_n), .sel(sel), .capture(capture), .shift(shift), .update(update),
    .tdi(tdi), .tdo(tdo), .status_in(status_in), .ram_rdata(ram_rdata), .ram_raddr(ram_raddr),
    .wptr_o(wptr_o), .trig_o(trig_o), .ctrl_o(ctrl_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] read_val(input logic [6:0] a);
    case (a)
      7'd0: return IDV;
      7'd1: return 32'(DEPTH);
      7'd2: return WIDV;
      7'd3: return 32'(status_in);
      7'd4: return mem[m_rptr];
      7'd5: return 32'(m_rptr);
      7'd6: return 32'(m_wptr);
      7'd7: return 32'(m_trig);
      7'd8: return 32'(m_ctrl);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check_outs(input string req);
    check({req, " rptr"}, 32'(ram_raddr), 32'(m_rptr));
    check({req, " wptr"}, 32'(wptr_o), 32'(m_wptr));
    check({req, " trig"}, 32'(trig_o), 32'(m_trig));
    check({req, " ctrl"}, 32'(ctrl_o), 32'(m_ctrl));
  endtask

  // One scan: capture, 40 shifts (flag, addr, data LSB first), update.
  task automatic scan(input logic wr, input logic [6:0] addr, input logic [31:0] data,
                      input string req);
    logic [39:0] vin, vout;
    logic [31:0] nv;
    vin = {data, addr, wr};
    @(negedge clk); sel = 1'b1; capture = 1'b1;
    @(negedge clk); capture = 1'b0; shift = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tdi = vin[i];
      vout[i] = tdo;
      @(negedge clk);
    end
    shift = 1'b0; update = 1'b1;
    @(negedge clk); update = 1'b0;
    check({req, " R4 returned data"}, vout[39:8], m_pend);
    check("R2 captured addr/flag zero", 32'(vout[7:0]), 32'd0);
    if (wr) begin
      case (addr)
        7'd5: m_rptr = data[PTR_W-1:0];
        7'd6: m_wptr = data[PTR_W-1:0];
        7'd7: m_trig = data[TRIG_W-1:0];
        7'd8: m_ctrl = data[CTRL_W-1:0];
        default: ;
      endcase
    end else begin
      nv = read_val(addr);
      if (addr == 7'd4) m_rptr = m_rptr + 1'b1;
      m_pend = nv;
    end
    check_outs({req, " R10"});
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < DEPTH; k++) mem[k] = $urandom;
    m_pend = '0; m_rptr = '0; m_wptr = '0; m_trig = '0; m_ctrl = '0;
    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7 tdo at reset", 32'(tdo), 32'd0);
    check_outs("R7 reset");
    rst_n = 1'b1;
    @(negedge clk);
    // R9 fixed registers
    scan(1'b0, 7'd0, 32'hFFFF_FFFF, "R7 first scan zero");
    scan(1'b0, 7'd1, '0, "R9 ident");
    scan(1'b0, 7'd2, '0, "R9 depth");
    status_in = 4'hA;
    scan(1'b0, 7'd3, '0, "R9 width");
    scan(1'b0, 7'd9, '0, "R9 status");
    // R3 writes and readback
    scan(1'b1, 7'd8, 32'hFFFF_FFFF, "R6 zero read of 9");
    scan(1'b1, 7'd7, 32'hDEAD_BEEF, "R3 ctrl wr");
    scan(1'b1, 7'd6, 32'h0000_0007, "R3 trig wr");
    scan(1'b0, 7'd8, '0, "R3");
    scan(1'b0, 7'd7, '0, "R3 ctrl rd");
    // R6 read-only and out of range writes
    scan(1'b1, 7'd0, 32'h1234_5678, "R3 trig rd");
    scan(1'b1, 7'd3, 32'h1234_5678, "R6");
    scan(1'b1, 7'd4, 32'h1234_5678, "R6");
    scan(1'b1, 7'd127, 32'h1234_5678, "R6");
    scan(1'b0, 7'd0, '0, "R6");
    scan(1'b0, 7'd127, '0, "R6 ident kept");
    // R5 streaming with wrap
    scan(1'b1, 7'd5, DEPTH - 3, "R6 127 zero");
    for (int k = 0; k < DEPTH + 4; k++) scan(1'b0, 7'd4, '0, "R5 stream");
    // R8 deselected strobes ignored
    @(negedge clk); sel = 1'b0; capture = 1'b1;
    @(negedge clk); capture = 1'b0; shift = 1'b1; tdi = 1'b1;
    repeat (5) @(negedge clk);
    shift = 1'b0; update = 1'b1;
    @(negedge clk); update = 1'b0;
    check_outs("R8 deselected");
    scan(1'b0, 7'd5, '0, "R8 pending kept");
    // R1 random mix
    for (int n = 0; n < 300; n++) begin
      logic [6:0] a;
      a = ($urandom % 4 == 0) ? 7'($urandom) : 7'($urandom % 10);
      status_in = STAT_W'($urandom);
      scan(1'($urandom), a, $urandom, "R1 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule